// File: doc/BRIEF.md
# Host Port Control and Request Logic

This block is the host-facing half of a byte-wide mailbox between an external host and an embedded processor. The host sees a small 3-bit address space with chip select and separate active-high read and write strobes. Address 0 holds a four-bit control register. Two data addresses carry the high and low bytes of a 16-bit word. Host writes fill the transmit word bound for the processor. Host reads return the receive word that the processor has loaded.

The control register sets the byte order, which swaps the two data addresses. It also holds a general-purpose flag that the processor side can see but cannot change, and two per-direction request enables. In interrupt mode the enables gate the transmit-empty and receive-full conditions onto a single host request output. In DMA mode the same two bits choose the transfer direction, and the request output paces only that direction.

Top module: `host_port_ctl`

## Requirements
- R1: After reset the control register reads 0, `host_flag` is 0, `tx_full` and `rx_full` are 0, and `host_req` is 0.
- R2: A host write to address 0 stores data bits 3:0 as {flag, byte order, transmit enable, receive enable}. Bit 3 drives `host_flag`, and nothing on the processor side can change it. A read of address 0 returns those four bits with bits 7:4 as zero.
- R3: With the byte-order bit (control bit 2) clear, address 6 is the high byte (word bits 15:8) and address 7 is the low byte (bits 7:0). With it set, address 7 is the high byte and address 6 is the low byte. This applies to both transmit writes and receive reads.
- R4: In interrupt mode (`dma_mode`=0), `host_req` = (control bit 1 AND transmit empty) OR (control bit 0 AND `rx_full`), where transmit empty means NOT `tx_full`. A cleared enable masks its condition.
- R5: In DMA mode, control bit 1 alone selects host-to-processor: `dma_h2p`=1 and `host_req` follows transmit empty. Control bit 0 alone selects processor-to-host: `dma_p2h`=1 and `host_req` follows `rx_full`. With neither bit or both bits set, `host_req`, `dma_h2p` and `dma_p2h` are 0.
- R6: A host write to the low byte address sets `tx_full` on the next clock edge. A write to the high byte address only updates that byte. `tx_take` clears `tx_full`. A low-byte write in the same cycle as `tx_take` leaves `tx_full` set.
- R7: `rx_load` latches `rx_data` and sets `rx_full`. A host read of the low byte address clears `rx_full`. An `rx_load` in the same cycle as that read leaves `rx_full` set, holding the new word.
- R8: Host writes take effect on the clock edge at which the strobe is sampled. `hdout` is 0 unless `hcs` and `hrd` are both high. Addresses other than 0, 6 and 7 read as 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hcs | input | 1 | Host chip select |
| hrd | input | 1 | Host read strobe |
| hwr | input | 1 | Host write strobe |
| haddr | input | 3 | Host address |
| hdin | input | 8 | Host write data |
| hdout | output | 8 | Host read data |
| dma_mode | input | 1 | 1 selects DMA pacing, 0 selects interrupt mode |
| rx_load | input | 1 | Processor loads a new receive word |
| rx_data | input | 16 | Receive word from the processor |
| tx_take | input | 1 | Processor has consumed the transmit word |
| tx_word | output | 16 | Transmit word toward the processor |
| tx_full | output | 1 | Transmit word waiting for the processor |
| rx_full | output | 1 | Receive word waiting for the host |
| host_flag | output | 1 | General-purpose flag from the host |
| host_req | output | 1 | Host request output |
| dma_h2p | output | 1 | DMA direction host-to-processor selected |
| dma_p2h | output | 1 | DMA direction processor-to-host selected |

## Verification
Each status flag has a set source and a clear source that can land on the same edge. For `rx_full`, the processor's `rx_load` can meet a host read of the low byte. For `tx_full`, a host low-byte write can meet `tx_take`. The bench drives both sources of a pair in one cycle. It then judges the result through `rx_full` or `tx_full`, and for the receive case also through read-back bytes that must equal the newly loaded word.

// File: rtl/host_port_pkg.sv
package host_port_pkg;

    localparam int HP_ADDR_W    = 3;
    localparam int HP_BYTE_W    = 8;
    localparam int HP_LANES     = 2;
    localparam int HP_WORD_W    = HP_BYTE_W * HP_LANES;
    localparam int HP_CTRL_ADDR = 0;
    localparam int HP_DATA_BASE = 6;
    localparam int HP_CTRL_W    = 4;

    // control register layout, MSB first: bit3 flag, bit2 order, bit1 tx en, bit0 rx en
    typedef struct packed {
        logic hflag;
        logic little;
        logic tx_en;
        logic rx_en;
    } ctrl_t;

endpackage

// File: rtl/host_port_decode.sv
module host_port_decode
    import host_port_pkg::*;
#(
    parameter int ADDR_W    = HP_ADDR_W,
    parameter int LANES     = HP_LANES,
    parameter int CTRL_ADDR = HP_CTRL_ADDR,
    parameter int DATA_BASE = HP_DATA_BASE
) (
    input  logic [ADDR_W-1:0] haddr,
    input  logic              little,
    output logic              ctrl_hit,
    output logic [LANES-1:0]  lane_hit
);

    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);

    assign ctrl_hit = (haddr == CTRL_A);

    // lane 0 is the least significant byte of the word
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam logic [ADDR_W-1:0] BIG_A = ADDR_W'(DATA_BASE + LANES - 1 - i);
        localparam logic [ADDR_W-1:0] LIT_A = ADDR_W'(DATA_BASE + i);
        assign lane_hit[i] = (haddr == (little ? LIT_A : BIG_A));
    end

endmodule

// File: rtl/host_port_regs.sv
module host_port_regs
    import host_port_pkg::*;
#(
    parameter int BYTE_W = HP_BYTE_W,
    parameter int LANES  = HP_LANES,
    localparam int WORD_W = BYTE_W * LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic              rd_stb,
    input  logic              ctrl_hit,
    input  logic [LANES-1:0]  lane_hit,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              rx_load,
    input  logic [WORD_W-1:0] rx_data,
    input  logic              tx_take,
    output ctrl_t             ctrl_q,
    output logic [WORD_W-1:0] tx_word_q,
    output logic              tx_full_q,
    output logic [WORD_W-1:0] rx_word_q,
    output logic              rx_full_q
);

    typedef struct packed {
        ctrl_t             ctrl;
        logic [WORD_W-1:0] tx_word;
        logic              tx_full;
        logic [WORD_W-1:0] rx_word;
        logic              rx_full;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;

        if (wr_stb && ctrl_hit) begin
            st_d.ctrl = ctrl_t'(wdata[HP_CTRL_W-1:0]);
        end

        for (int i = 0; i < LANES; i++) begin
            if (wr_stb && lane_hit[i]) begin
                st_d.tx_word[i*BYTE_W +: BYTE_W] = wdata;
            end
        end

        // transmit flag: the host low-byte write outranks the processor take
        if (tx_take) begin
            st_d.tx_full = 1'b0;
        end
        if (wr_stb && lane_hit[0]) begin
            st_d.tx_full = 1'b1;
        end

        // receive flag: a fresh load outranks the host low-byte read
        if (rd_stb && lane_hit[0]) begin
            st_d.rx_full = 1'b0;
        end
        if (rx_load) begin
            st_d.rx_full = 1'b1;
            st_d.rx_word = rx_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl_q    = st_q.ctrl;
    assign tx_word_q = st_q.tx_word;
    assign tx_full_q = st_q.tx_full;
    assign rx_word_q = st_q.rx_word;
    assign rx_full_q = st_q.rx_full;

endmodule

// File: rtl/host_port_rdmux.sv
module host_port_rdmux
    import host_port_pkg::*;
#(
    parameter int BYTE_W = HP_BYTE_W,
    parameter int LANES  = HP_LANES,
    localparam int WORD_W = BYTE_W * LANES
) (
    input  logic              rd_stb,
    input  logic              ctrl_hit,
    input  logic [LANES-1:0]  lane_hit,
    input  ctrl_t             ctrl,
    input  logic [WORD_W-1:0] rx_word,
    output logic [BYTE_W-1:0] rdata
);

    always_comb begin
        rdata = '0;
        if (rd_stb) begin
            if (ctrl_hit) begin
                rdata = BYTE_W'(ctrl);
            end
            for (int i = 0; i < LANES; i++) begin
                if (lane_hit[i]) begin
                    rdata = rx_word[i*BYTE_W +: BYTE_W];
                end
            end
        end
    end

endmodule

// File: rtl/host_port_req.sv
module host_port_req
    import host_port_pkg::*;
(
    input  logic  dma_mode,
    input  ctrl_t ctrl,
    input  logic  tx_full,
    input  logic  rx_full,
    output logic  host_req,
    output logic  dma_h2p,
    output logic  dma_p2h
);

    logic tx_empty;
    logic irq_req;
    logic dma_req;

    assign tx_empty = ~tx_full;

    always_comb begin
        // interrupt mode: both gated conditions share the one output
        irq_req = (ctrl.tx_en & tx_empty) | (ctrl.rx_en & rx_full);

        // DMA mode: exactly one enable names the direction
        dma_h2p = dma_mode &  ctrl.tx_en & ~ctrl.rx_en;
        dma_p2h = dma_mode & ~ctrl.tx_en &  ctrl.rx_en;
        dma_req = (dma_h2p & tx_empty) | (dma_p2h & rx_full);

        host_req = dma_mode ? dma_req : irq_req;
    end

endmodule

// File: rtl/host_port_ctl.sv
module host_port_ctl
    import host_port_pkg::*;
#(
    parameter int ADDR_W    = HP_ADDR_W,
    parameter int BYTE_W    = HP_BYTE_W,
    parameter int LANES     = HP_LANES,
    parameter int CTRL_ADDR = HP_CTRL_ADDR,
    parameter int DATA_BASE = HP_DATA_BASE,
    localparam int WORD_W   = BYTE_W * LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hcs,
    input  logic              hrd,
    input  logic              hwr,
    input  logic [ADDR_W-1:0] haddr,
    input  logic [BYTE_W-1:0] hdin,
    output logic [BYTE_W-1:0] hdout,
    input  logic              dma_mode,
    input  logic              rx_load,
    input  logic [WORD_W-1:0] rx_data,
    input  logic              tx_take,
    output logic [WORD_W-1:0] tx_word,
    output logic              tx_full,
    output logic              rx_full,
    output logic              host_flag,
    output logic              host_req,
    output logic              dma_h2p,
    output logic              dma_p2h
);

    logic             wr_stb;
    logic             rd_stb;
    logic             ctrl_hit;
    logic [LANES-1:0] lane_hit;
    ctrl_t            ctrl_q;
    logic [WORD_W-1:0] rx_word_q;

    assign wr_stb = hcs & hwr;
    assign rd_stb = hcs & hrd;

    host_port_decode #(
        .ADDR_W   (ADDR_W),
        .LANES    (LANES),
        .CTRL_ADDR(CTRL_ADDR),
        .DATA_BASE(DATA_BASE)
    ) u_decode (
        .haddr   (haddr),
        .little  (ctrl_q.little),
        .ctrl_hit(ctrl_hit),
        .lane_hit(lane_hit)
    );

    host_port_regs #(
        .BYTE_W(BYTE_W),
        .LANES (LANES)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_stb   (wr_stb),
        .rd_stb   (rd_stb),
        .ctrl_hit (ctrl_hit),
        .lane_hit (lane_hit),
        .wdata    (hdin),
        .rx_load  (rx_load),
        .rx_data  (rx_data),
        .tx_take  (tx_take),
        .ctrl_q   (ctrl_q),
        .tx_word_q(tx_word),
        .tx_full_q(tx_full),
        .rx_word_q(rx_word_q),
        .rx_full_q(rx_full)
    );

    host_port_rdmux #(
        .BYTE_W(BYTE_W),
        .LANES (LANES)
    ) u_rdmux (
        .rd_stb  (rd_stb),
        .ctrl_hit(ctrl_hit),
        .lane_hit(lane_hit),
        .ctrl    (ctrl_q),
        .rx_word (rx_word_q),
        .rdata   (hdout)
    );

    host_port_req u_req (
        .dma_mode(dma_mode),
        .ctrl    (ctrl_q),
        .tx_full (tx_full),
        .rx_full (rx_full),
        .host_req(host_req),
        .dma_h2p (dma_h2p),
        .dma_p2h (dma_p2h)
    );

    assign host_flag = ctrl_q.hflag;

endmodule

// File: rtl/host_port_ctl_chk.sv
module host_port_ctl_chk
    import host_port_pkg::*;
#(
    parameter int ADDR_W    = HP_ADDR_W,
    parameter int BYTE_W    = HP_BYTE_W,
    parameter int LANES     = HP_LANES,
    parameter int CTRL_ADDR = HP_CTRL_ADDR,
    parameter int DATA_BASE = HP_DATA_BASE
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hcs,
    input logic              hrd,
    input logic              hwr,
    input logic [ADDR_W-1:0] haddr,
    input logic [BYTE_W-1:0] hdout,
    input logic              dma_mode,
    input logic              rx_load,
    input logic              tx_take,
    input logic              tx_full,
    input logic              rx_full,
    input logic              host_flag,
    input logic              host_req,
    input ctrl_t             ctrl
);

    logic [ADDR_W-1:0] low_addr;
    logic              wr_low;
    logic              rd_low;
    logic              wr_ctrl;

    assign low_addr = ctrl.little ? ADDR_W'(DATA_BASE) : ADDR_W'(DATA_BASE + LANES - 1);
    assign wr_low   = hcs && hwr && (haddr == low_addr);
    assign rd_low   = hcs && hrd && (haddr == low_addr);
    assign wr_ctrl  = hcs && hwr && (haddr == ADDR_W'(CTRL_ADDR));

    // R2: the flag moves only on a host write to the control address
    a_r2_flag_host_only: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ctrl |=> $stable(host_flag));

    // R2: upper control bits always read as zero
    a_r2_ctrl_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (hcs && hrd && haddr == ADDR_W'(CTRL_ADDR)) |-> (hdout[BYTE_W-1:HP_CTRL_W] == '0));

    // R4: both enables clear in interrupt mode keep the request low
    a_r4_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!dma_mode && !ctrl.tx_en && !ctrl.rx_en) |-> !host_req);

    // R5: ambiguous DMA direction never requests
    a_r5_dma_both_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_mode && ctrl.tx_en && ctrl.rx_en) |-> !host_req);

    // R6: low-byte write marks the transmit word full, whatever tx_take does
    a_r6_low_write_full: assert property (@(posedge clk) disable iff (!rst_n)
        wr_low |=> tx_full);

    // R6: a full transmit word stays full until taken
    a_r6_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_full && !tx_take) |=> tx_full);

    // R7: a load always leaves the receive word full
    a_r7_load_full: assert property (@(posedge clk) disable iff (!rst_n)
        rx_load |=> rx_full);

    // R7: a low-byte read without a load empties the receive word
    a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_low && !rx_load) |=> !rx_full);

    // R8: read data is zero outside a read strobe
    a_r8_idle_bus_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !(hcs && hrd) |-> (hdout == '0));

endmodule

bind host_port_ctl host_port_ctl_chk #(
    .ADDR_W   (ADDR_W),
    .BYTE_W   (BYTE_W),
    .LANES    (LANES),
    .CTRL_ADDR(CTRL_ADDR),
    .DATA_BASE(DATA_BASE)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .hcs      (hcs),
    .hrd      (hrd),
    .hwr      (hwr),
    .haddr    (haddr),
    .hdout    (hdout),
    .dma_mode (dma_mode),
    .rx_load  (rx_load),
    .tx_take  (tx_take),
    .tx_full  (tx_full),
    .rx_full  (rx_full),
    .host_flag(host_flag),
    .host_req (host_req),
    .ctrl     (ctrl_q)
);

// File: tb/host_port_ctl_tb.sv
module host_port_ctl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hcs = 1'b0;
    logic        hrd = 1'b0;
    logic        hwr = 1'b0;
    logic [2:0]  haddr = '0;
    logic [7:0]  hdin = '0;
    logic [7:0]  hdout;
    logic        dma_mode = 1'b0;
    logic        rx_load = 1'b0;
    logic [15:0] rx_data = '0;
    logic        tx_take = 1'b0;
    logic [15:0] tx_word;
    logic        tx_full;
    logic        rx_full;
    logic        host_flag;
    logic        host_req;
    logic        dma_h2p;
    logic        dma_p2h;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    host_port_ctl u_dut (
        .clk(clk), .rst_n(rst_n), .hcs(hcs), .hrd(hrd), .hwr(hwr),
        .haddr(haddr), .hdin(hdin), .hdout(hdout), .dma_mode(dma_mode),
        .rx_load(rx_load), .rx_data(rx_data), .tx_take(tx_take),
        .tx_word(tx_word), .tx_full(tx_full), .rx_full(rx_full),
        .host_flag(host_flag), .host_req(host_req),
        .dma_h2p(dma_h2p), .dma_p2h(dma_p2h)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic host_wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        hcs = 1'b1; hwr = 1'b1; haddr = a; hdin = d;
        @(negedge clk);
        hcs = 1'b0; hwr = 1'b0;
    endtask

    task automatic host_rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        hcs = 1'b1; hrd = 1'b1; haddr = a;
        #1 d = hdout;
        @(negedge clk);
        hcs = 1'b0; hrd = 1'b0;
    endtask

    task automatic proc_load(input logic [15:0] w);
        @(negedge clk);
        rx_load = 1'b1; rx_data = w;
        @(negedge clk);
        rx_load = 1'b0;
    endtask

    task automatic proc_take();
        @(negedge clk);
        tx_take = 1'b1;
        @(negedge clk);
        tx_take = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        chk("R1 host_flag", 16'(host_flag), 16'h0);
        chk("R1 tx_full", 16'(tx_full), 16'h0);
        chk("R1 rx_full", 16'(rx_full), 16'h0);
        chk("R1 host_req", 16'(host_req), 16'h0);
        host_rd(3'd0, d);
        chk("R1 ctrl read", 16'(d), 16'h0);
    endtask

    task automatic t_flag();
        logic [7:0] d;
        host_wr(3'd0, 8'h08);
        chk("R2 flag set", 16'(host_flag), 16'h1);
        host_rd(3'd0, d);
        chk("R2 ctrl readback", 16'(d), 16'h08);
        host_wr(3'd0, 8'hF8);
        host_rd(3'd0, d);
        chk("R2 upper bits zero", 16'(d), 16'h08);
        host_wr(3'd0, 8'h00);
        chk("R2 flag clear", 16'(host_flag), 16'h0);
        chk("R8 idle bus", 16'(hdout), 16'h0);
    endtask

    task automatic t_endian();
        logic [7:0] d;
        proc_load(16'hA55A);
        chk("R7 load sets full", 16'(rx_full), 16'h1);
        host_rd(3'd6, d);
        chk("R3 big addr6 high", 16'(d), 16'hA5);
        chk("R7 high read keeps full", 16'(rx_full), 16'h1);
        host_rd(3'd7, d);
        chk("R3 big addr7 low", 16'(d), 16'h5A);
        chk("R7 low read clears", 16'(rx_full), 16'h0);
        host_wr(3'd0, 8'h04);
        host_rd(3'd6, d);
        chk("R3 little addr6 low", 16'(d), 16'h5A);
        host_rd(3'd7, d);
        chk("R3 little addr7 high", 16'(d), 16'hA5);
        host_wr(3'd7, 8'h12);
        chk("R6 high write no full", 16'(tx_full), 16'h0);
        host_wr(3'd6, 8'h34);
        chk("R6 low write full", 16'(tx_full), 16'h1);
        chk("R3 little tx word", tx_word, 16'h1234);
        host_wr(3'd0, 8'h00);
        proc_take();
        chk("R6 take clears", 16'(tx_full), 16'h0);
        host_wr(3'd6, 8'h9A);
        chk("R3 big high write no full", 16'(tx_full), 16'h0);
        host_wr(3'd7, 8'hBC);
        chk("R3 big tx word", tx_word, 16'h9ABC);
    endtask

    task automatic t_irq();
        // tx_full=1, rx_full=0 on entry
        host_wr(3'd0, 8'h02);
        chk("R4 tx en but full", 16'(host_req), 16'h0);
        proc_take();
        chk("R4 tx en and empty", 16'(host_req), 16'h1);
        host_wr(3'd0, 8'h00);
        chk("R4 tx masked", 16'(host_req), 16'h0);
        host_wr(3'd0, 8'h01);
        chk("R4 rx en but empty", 16'(host_req), 16'h0);
        proc_load(16'h0F0F);
        chk("R4 rx en and full", 16'(host_req), 16'h1);
        host_wr(3'd7, 8'h11);
        host_wr(3'd0, 8'h02);
        chk("R4 rx masked", 16'(host_req), 16'h0);
        host_wr(3'd0, 8'h03);
        chk("R4 both or", 16'(host_req), 16'h1);
        chk("R5 no dir in irq", 16'({dma_h2p, dma_p2h}), 16'h0);
    endtask

    task automatic t_dma();
        logic [7:0] d;
        // tx_full=1, rx_full=1 on entry
        @(negedge clk);
        dma_mode = 1'b1;
        host_wr(3'd0, 8'h02);
        chk("R5 h2p dir", 16'({dma_h2p, dma_p2h}), 16'h2);
        chk("R5 h2p ignores rx", 16'(host_req), 16'h0);
        proc_take();
        chk("R5 h2p paces", 16'(host_req), 16'h1);
        host_wr(3'd0, 8'h01);
        chk("R5 p2h dir", 16'({dma_h2p, dma_p2h}), 16'h1);
        chk("R5 p2h paces", 16'(host_req), 16'h1);
        host_rd(3'd7, d);
        chk("R5 p2h ignores tx", 16'(host_req), 16'h0);
        host_wr(3'd0, 8'h03);
        chk("R5 both quiet", 16'({host_req, dma_h2p, dma_p2h}), 16'h0);
        host_wr(3'd0, 8'h00);
        chk("R5 none quiet", 16'({host_req, dma_h2p, dma_p2h}), 16'h0);
        @(negedge clk);
        dma_mode = 1'b0;
    endtask

    task automatic t_collide();
        logic [7:0] d;
        // tx_full=0, rx_full=0 on entry
        proc_load(16'h1357);
        @(negedge clk);
        hcs = 1'b1; hrd = 1'b1; haddr = 3'd7;
        rx_load = 1'b1; rx_data = 16'hBEEF;
        @(negedge clk);
        hcs = 1'b0; hrd = 1'b0; rx_load = 1'b0;
        chk("R7 load beats read", 16'(rx_full), 16'h1);
        host_rd(3'd6, d);
        chk("R7 new high byte", 16'(d), 16'hBE);
        host_rd(3'd7, d);
        chk("R7 new low byte", 16'(d), 16'hEF);
        @(negedge clk);
        hcs = 1'b1; hwr = 1'b1; haddr = 3'd7; hdin = 8'h44;
        tx_take = 1'b1;
        @(negedge clk);
        hcs = 1'b0; hwr = 1'b0; tx_take = 1'b0;
        chk("R6 write beats take", 16'(tx_full), 16'h1);
    endtask

    task automatic t_unmapped();
        logic [7:0] d;
        host_wr(3'd0, 8'h08);
        host_wr(3'd3, 8'hFF);
        host_rd(3'd3, d);
        chk("R8 unmapped read", 16'(d), 16'h0);
        host_rd(3'd0, d);
        chk("R8 unmapped write ignored", 16'(d), 16'h08);
        @(negedge clk);
        hcs = 1'b0; hrd = 1'b1; haddr = 3'd0;
        #1 chk("R8 no cs no data", 16'(hdout), 16'h0);
        @(negedge clk);
        hrd = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_flag();
        t_endian();
        t_irq();
        t_dma();
        t_collide();
        t_unmapped();
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule